// File: doc/BRIEF.md
# Converter Start and Busy Sequencer

This block is the digital control of a 10-bit converter with five selectable inputs: an on-chip temperature sensor on channel 0 and four single-ended voltage inputs on channels 1 to 4. A falling edge on the active-low start input begins a conversion. The block puts the track/hold into hold and raises `busy` for a fixed number of system clock cycles. When the conversion ends, it latches the converted value and returns the track/hold to track.

The analog comparator and capacitor array are modelled by the `result_in` input, which the block samples on the final conversion cycle. When the start input is still low at that point, the block enters power-down. The next falling edge wakes it and starts a new conversion.

A temperature result whose upper 8 bits exceed an 8-bit threshold drives the active-low over-temperature flag. A finished serial read clears the flag again. The block sees a finished read as a rising read/write line while the port is selected.

Top module: `adc_conv_seq`

## Requirements
- R1: A falling edge on `cnv_start_n`, seen while `busy` is low, sets both `busy` and `hold` on the next clock edge.
- R2: `hold` is high exactly while `busy` is high. Both return low on the same edge, so the track/hold is tracking again when a conversion ends.
- R3: `busy` stays high for exactly CONV_CYCLES clock cycles for every conversion, whichever channel is selected.
- R4: On the edge that ends a conversion, `pwr_down` takes the inverse of the `cnv_start_n` level seen at that edge. A start that begins a conversion clears `pwr_down`, so a falling edge out of power-down wakes the block.
- R5: On the edge that ends a conversion, `result` takes the 10-bit `result_in` value and `result_chan` takes the channel of that conversion. Neither output changes at any other time.
- R6: `chan_sel` is captured on the start edge. Codes 0 to 4 select that channel, and codes 5 to 7 select channel 4.
- R7: `ot_n` goes low at the end of a conversion only if the channel is 0 and `result_in[9:2]` is strictly greater than `thresh`. An equal value, or a result from any other channel, leaves `ot_n` unchanged.
- R8: A rising edge on `rdwr` while `cs_n` is low sets `ot_n` high. A rising edge while `cs_n` is high has no effect. If a read completes on the same edge that raises the flag, setting the flag wins.
- R9: A falling edge on `cnv_start_n` while `busy` is high is ignored. The running conversion keeps its length, channel and result.
- R10: After reset, `busy`, `hold` and `pwr_down` are low, `result` and `result_chan` are 0, and `ot_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_start_n | input | 1 | Convert start; falling edge starts, level at end selects power-down |
| chan_sel | input | 3 | Channel address (0 = temperature sensor) |
| thresh | input | 8 | Over-temperature threshold |
| result_in | input | 10 | Behavioural converter output, sampled on the last conversion cycle |
| cs_n | input | 1 | Serial port select, active low |
| rdwr | input | 1 | Serial read/write line; rising edge with cs_n low marks a finished read |
| busy | output | 1 | High while a conversion runs |
| hold | output | 1 | Track/hold in hold mode |
| pwr_down | output | 1 | Block is powered down |
| result | output | 10 | Last conversion result |
| result_chan | output | 3 | Channel of the last conversion |
| ot_n | output | 1 | Over-temperature flag, active low |

## Verification
The assertions check, on every cycle, the following behaviour:
- a start from idle raises `busy`;
- `hold` mirrors `busy`;
- `busy` never runs longer than the conversion time;
- `pwr_down` matches the start level at completion;
- `result` changes only when a conversion ends;
- `ot_n` falls only for a channel-0 value above the threshold;
- a selected read raises `ot_n`.

The scenarios are needed to show that `busy` lasts the exact number of cycles, which values are latched, how out-of-range channel codes are clamped, the equal-to-threshold case, reads made while deselected, the start edge ignored during a conversion, and waking from power-down.

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int CONV_CYCLES = 20,
  parameter int RES_W       = 10,
  parameter int TH_W        = 8,
  parameter int CH_W        = 3,
  parameter int LAST_CH     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv_start_n,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic [TH_W-1:0]  thresh,
  input  logic [RES_W-1:0] result_in,
  input  logic             cs_n,
  input  logic             rdwr,
  output logic             busy,
  output logic             hold,
  output logic             pwr_down,
  output logic [RES_W-1:0] result,
  output logic [CH_W-1:0]  result_chan,
  output logic             ot_n
);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic            start_q, rdwr_q;
  logic [CW-1:0]   cnt;
  logic [CH_W-1:0] ch_q;

  wire start_fall = start_q & ~cnv_start_n;
  wire rd_done    = ~rdwr_q & rdwr & ~cs_n;
  wire conv_last  = busy && (cnt == CW'(CONV_CYCLES - 1));
  wire ot_hit     = conv_last && (ch_q == '0) && (result_in[RES_W-1 -: TH_W] > thresh);
  wire [CH_W-1:0] ch_sat = (chan_sel > CH_W'(LAST_CH)) ? CH_W'(LAST_CH) : chan_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b1;
      rdwr_q  <= 1'b0;
    end else begin
      start_q <= cnv_start_n;
      rdwr_q  <= rdwr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      hold        <= 1'b0;
      pwr_down    <= 1'b0;
      cnt         <= '0;
      ch_q        <= '0;
      result      <= '0;
      result_chan <= '0;
    end else if (!busy) begin
      if (start_fall) begin
        busy     <= 1'b1;
        hold     <= 1'b1;
        pwr_down <= 1'b0;
        cnt      <= '0;
        ch_q     <= ch_sat;
      end
    end else if (conv_last) begin
      busy        <= 1'b0;
      hold        <= 1'b0;
      pwr_down    <= ~cnv_start_n;
      result      <= result_in;
      result_chan <= ch_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ot_n <= 1'b1;
    else if (ot_hit)  ot_n <= 1'b0;
    else if (rd_done) ot_n <= 1'b1;
  end
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int CONV_CYCLES = 20,
  parameter int RES_W       = 10,
  parameter int TH_W        = 8,
  parameter int CH_W        = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnv_start_n,
  input logic [TH_W-1:0]  thresh,
  input logic             cs_n,
  input logic             rdwr,
  input logic             busy,
  input logic             hold,
  input logic             pwr_down,
  input logic [RES_W-1:0] result,
  input logic [CH_W-1:0]  result_chan,
  input logic             ot_n
);
  int bcnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $fell(cnv_start_n) && !busy |=> busy && hold); // R1
  AST_HOLD_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) hold == busy); // R2
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) busy |-> bcnt < CONV_CYCLES); // R3
  AST_PD_FROM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> pwr_down == !$past(cnv_start_n)); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !$fell(busy) |-> $stable(result) && $stable(result_chan)); // R5
  AST_OT_CH0_ONLY: assert property (@(posedge clk) disable iff (!rst_n) $fell(ot_n) |-> $fell(busy) && result_chan == '0 && result[RES_W-1 -: TH_W] > $past(thresh)); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) $rose(rdwr) && !cs_n && !busy |=> ot_n); // R8
endmodule

bind adc_conv_seq adc_conv_seq_chk #(.CONV_CYCLES(CONV_CYCLES), .RES_W(RES_W), .TH_W(TH_W), .CH_W(CH_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cnv_start_n(cnv_start_n), .thresh(thresh), .cs_n(cs_n), .rdwr(rdwr),
  .busy(busy), .hold(hold), .pwr_down(pwr_down), .result(result), .result_chan(result_chan), .ot_n(ot_n)
);

// File: tb/test_adc_conv_seq.sv
module test_adc_conv_seq;
  localparam int N = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnv_start_n = 1'b1, cs_n = 1'b1, rdwr = 1'b0;
  logic [2:0] chan_sel = '0;
  logic [7:0] thresh = '0;
  logic [9:0] result_in = '0;
  logic busy, hold, pwr_down, ot_n;
  logic [9:0] result;
  logic [2:0] result_chan;

  adc_conv_seq #(.CONV_CYCLES(N)) i_adc_conv_seq (
    .clk(clk), .rst_n(rst_n), .cnv_start_n(cnv_start_n), .chan_sel(chan_sel), .thresh(thresh),
    .result_in(result_in), .cs_n(cs_n), .rdwr(rdwr), .busy(busy), .hold(hold), .pwr_down(pwr_down),
    .result(result), .result_chan(result_chan), .ot_n(ot_n)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [9:0] res;
    logic [2:0] ch;
    logic       ot;
    logic       pd;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, errors = 0;
  bit   ot_model = 1'b1;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  bit busy_prev = 1'b0;
  int bcycles = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) bcycles++;
      if (busy_prev && !busy) begin
        exp_t e;
        chk(hold == 1'b0, "R2 hold released", int'(hold), 0);
        chk(bcycles == N, "R3 busy length", bcycles, N);
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected completion", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(result == e.res, "R5 result", int'(result), int'(e.res));
          chk(result_chan == e.ch, "R6 channel", int'(result_chan), int'(e.ch));
          chk(ot_n == e.ot, "R7 ot_n", int'(ot_n), int'(e.ot));
          chk(pwr_down == e.pd, "R4 pwr_down", int'(pwr_down), int'(e.pd));
        end
        bcycles = 0;
      end
      busy_prev = busy;
    end
  end

  task automatic convert(input logic [2:0] ch, input logic [9:0] res, input logic [7:0] th,
                         input bit end_low, input bit poke);
    logic [2:0] ce;
    bit ot;
    @(negedge clk);
    chan_sel = ch; result_in = res; thresh = th; cnv_start_n = 1'b1;
    @(negedge clk);
    cnv_start_n = 1'b0;
    ce = (ch > 3'd4) ? 3'd4 : ch;
    ot = (ce == 3'd0 && res[9:2] > th) ? 1'b0 : ot_model;
    ot_model = ot;
    exp_q.push_back('{res: res, ch: ce, ot: ot, pd: end_low});
    @(negedge clk);
    chk(busy && hold, "R1 start sets busy/hold", int'({busy, hold}), 3);
    chk(pwr_down == 1'b0, "R4 start clears pwr_down", int'(pwr_down), 0);
    chan_sel = 3'd2;
    if (poke) begin
      cnv_start_n = 1'b1;
      @(negedge clk);
      cnv_start_n = 1'b0; // R9 edge during busy
      @(negedge clk);
      @(negedge clk);
    end
    if (!end_low) cnv_start_n = 1'b1;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic serial_read(input bit sel);
    @(negedge clk);
    cs_n = !sel; rdwr = 1'b0;
    @(negedge clk);
    rdwr = 1'b1;
    @(negedge clk);
    if (sel) begin
      ot_model = 1'b1;
      chk(ot_n == 1'b1, "R8 selected read clears", int'(ot_n), 1);
    end else
      chk(ot_n == ot_model, "R8 deselected read no effect", int'(ot_n), int'(ot_model));
    cs_n = 1'b1; rdwr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !hold && !pwr_down, "R10 reset controls", int'({busy, hold, pwr_down}), 0);
    chk(result == '0 && result_chan == '0, "R10 reset result", int'(result), 0);
    chk(ot_n == 1'b1, "R10 reset ot_n", int'(ot_n), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    convert(3'd0, 10'h3FF, 8'h80, 1'b0, 1'b0);   // R7 above threshold
    serial_read(1'b0);                            // R8 deselected
    serial_read(1'b1);                            // R8 selected
    convert(3'd0, 10'h203, 8'h80, 1'b0, 1'b0);   // R7 equal upper bits
    convert(3'd2, 10'h3FF, 8'h00, 1'b0, 1'b0);   // R7 other channel
    convert(3'd7, 10'h0A5, 8'h10, 1'b0, 1'b0);   // R6 clamp
    convert(3'd1, 10'h155, 8'h10, 1'b0, 1'b1);   // R9 ignored edge
    convert(3'd3, 10'h2AA, 8'h10, 1'b1, 1'b0);   // R4 power-down
    repeat (5) @(negedge clk);
    chk(pwr_down == 1'b1 && !busy, "R4 stays powered down", int'(pwr_down), 1);
    convert(3'd4, 10'h011, 8'h10, 1'b0, 1'b0);   // R4 wake
    convert(3'd0, 10'h3FC, 8'hFE, 1'b0, 1'b0);   // R7 just above
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100us;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule